// File: doc/BRIEF.md
# Unaligned Operand Bus Cycle Splitter

This block sits between a processor's execution logic and a 16-bit external data bus with a 24-bit byte address. It takes one transfer request at a time. A request carries a byte address, an operand size of one, two or four bytes, a direction, a memory or I/O space select, a data or control cycle type, and write data. The block turns the request into the physical bus cycles the bus needs. It drives the word address, the two active-low lane enables, the address strobe and the cycle type lines for each cycle.

Every physical cycle has an address state and at least one data state. A slave stretches the cycle by holding the active-low ready input high. Bytes returned on a read are placed back at their logical positions in a 32-bit result. A single completion pulse tells the requester that the last cycle has ended. During reset, and whenever no cycle is in progress, every output sits at a fixed idle level.

Top module: `bsp_bus_splitter`

## Requirements
- R1: While `rst` is high, and in every state with no bus cycle in progress, the outputs are at the idle pattern: `bus_strobe_n`=1, `hi_lane_n`=0, `lo_lane_n`=0, `bus_addr` all ones, `bus_write`=0, `bus_data_cyc`=1, `bus_mem`=0, `bus_locked_n`=1, `bus_grant`=0, `bus_dout_en`=0.
- R2: A one-byte operand (`req_size`=0) takes one cycle at word address `addr[23:1]`. The low lane (`lo_lane_n`=0, bits 7:0) is enabled when `addr[0]`=0, and the high lane (`hi_lane_n`=0, bits 15:8) when `addr[0]`=1.
- R3: A two-byte operand (`req_size`=1) at an even address takes one cycle with both lanes enabled. Operand byte 0 is on the low lane.
- R4: A two-byte operand at an odd address takes two byte cycles. The first uses the high lane of word W=`addr[23:1]`. The second uses the low lane of word W+1.
- R5: A four-byte operand (`req_size`=2, or the reserved code 3) at an even address takes two full-word cycles: operand bytes 1:0 at W, then bytes 3:2 at W+1.
- R6: A four-byte operand at an odd address takes three cycles: the high lane at W carrying byte 0, both lanes at W+1 carrying bytes 2:1, then the low lane at W+2 carrying byte 3.
- R7: `bus_strobe_n` is low only in the first state of each cycle, and `bus_rdy_n` is ignored in that state. From the second state on, a cycle ends at the first clock edge where `bus_rdy_n` is sampled low. While it is high, the cycle stays on with unchanged address and lane enables.
- R8: On a write, `bus_dout_en` is high through every cycle. Each enabled lane carries the operand byte whose address maps to it, and a disabled lane carries zero. On a read, `bus_dout_en` stays low.
- R9: On a read, `rdata` byte i equals the bus byte at address `addr`+i for every i below the operand length. The bytes above the length are zero.
- R10: `done` is high for exactly one clock, starting at the edge that ends the last cycle. `req_ready` is high only when idle and out of reset. `req_valid` and all request fields are ignored while `req_ready` is low.
- R11: `bus_write`, `bus_mem` and `bus_data_cyc` follow the request's direction, space and type for all of its cycles. Word addresses wrap modulo 2^23. All address bits, `bus_addr[22]` (A23) included, are driven as given for I/O cycles too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 24 | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_data | input | 1 | 1 data cycle, 0 control/code cycle |
| req_wdata | input | 32 | Write operand, byte 0 in bits 7:0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand |
| bus_addr | output | 23 | Word address (byte address bits 23:1) |
| bus_strobe_n | output | 1 | Address strobe, active low |
| hi_lane_n | output | 1 | Upper lane enable, active low |
| lo_lane_n | output | 1 | Lower lane enable, active low |
| bus_write | output | 1 | Cycle direction, 1 write |
| bus_data_cyc | output | 1 | Cycle type, 1 data |
| bus_mem | output | 1 | Space select, 1 memory |
| bus_locked_n | output | 1 | Locked-cycle indicator, held inactive high |
| bus_grant | output | 1 | Hold acknowledge, held low |
| bus_dout | output | 16 | Write data lanes |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data lanes |
| bus_rdy_n | input | 1 | Cycle ready, active low |

## Verification
The bench aims at the odd-address operands, where a design that ordered cycles by lane, dropped the carry into the next word address, or put a byte on the wrong lane would issue cycles the scoreboard does not expect. It drives ready low during every address state and inserts varied wait states. A design that ended a cycle early or did not stretch it would move the completion pulse off its computed clock. An odd-address dword at the top of memory checks that the word address wraps, and an I/O cycle at a coprocessor-style address checks that A23 is still driven. A request held valid with changing fields during a long transfer would show up as extra or altered cycles in a design that re-sampled its inputs while busy.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int LANES  = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_T1   = 2'd1,
    BUS_T2   = 2'd2
  } bus_state_e;

  // operand length in bytes from the size code
  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // number of 16-bit words touched by the byte span [a0, a0+nb-1]
  function automatic logic [1:0] cycles_for(input logic a0, input logic [2:0] nb);
    logic [3:0] last_off;
    last_off = {3'b000, a0} + {1'b0, nb} - 4'd1;
    return last_off[2:1] + 2'd1;
  endfunction

  // does lane 'hi' of bus cycle k carry a byte of the operand
  function automatic logic lane_hit(input logic [1:0] k, input logic hi,
                                    input logic a0, input logic [2:0] nb);
    logic [3:0] pos;
    logic [3:0] off;
    pos = {1'b0, k, hi};
    off = pos - {3'b000, a0};
    return (pos >= {3'b000, a0}) && (off < {1'b0, nb});
  endfunction

  // operand byte index carried by lane 'hi' of bus cycle k
  function automatic logic [1:0] lane_byte(input logic [1:0] k, input logic hi,
                                           input logic a0);
    logic [3:0] off;
    off = {1'b0, k, hi} - {3'b000, a0};
    return off[1:0];
  endfunction

endpackage

// File: rtl/bsp_planner.sv
module bsp_planner
  import bsp_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]          base_addr,
  input  logic [2:0]                 nbytes,
  input  logic [1:0]                 cyc_idx,
  input  logic [4*BYTE_W-1:0]        wdata,
  output logic [ADDR_W-2:0]          word_addr,
  output logic [LANES-1:0]           lane_en,
  output logic [LANES-1:0][1:0]      lane_idx,
  output logic [LANES*BYTE_W-1:0]    lane_wdata
);

  localparam int WA = ADDR_W - 1;

  // consecutive cycles walk consecutive words; wraps naturally at WA bits
  assign word_addr = base_addr[ADDR_W-1:1] + WA'(cyc_idx);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l]  = lane_hit(cyc_idx, 1'(l), base_addr[0], nbytes);
    assign lane_idx[l] = lane_byte(cyc_idx, 1'(l), base_addr[0]);
    assign lane_wdata[l*BYTE_W +: BYTE_W] =
      lane_en[l] ? wdata[{lane_idx[l], 3'b000} +: BYTE_W] : '0;
  end

endmodule

// File: rtl/bsp_sequencer.sv
module bsp_sequencer
  import bsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rdy_n,
  input  logic [1:0] ncyc,
  output bus_state_e state,
  output logic [1:0] cyc_idx,
  output logic       cycle_end,
  output logic       last_end
);

  bus_state_e state_q;
  logic [1:0] idx_q;

  assign state     = state_q;
  assign cyc_idx   = idx_q;
  // ready is only looked at from the second state of a cycle on
  assign cycle_end = (state_q == BUS_T2) && !rdy_n;
  assign last_end  = cycle_end && (idx_q == ncyc - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        BUS_IDLE: begin
          idx_q <= '0;
          if (start) state_q <= BUS_T1;
        end
        BUS_T1: state_q <= BUS_T2;
        BUS_T2: begin
          if (last_end) begin
            state_q <= BUS_IDLE;
            idx_q   <= '0;
          end else if (cycle_end) begin
            state_q <= BUS_T1;
            idx_q   <= idx_q + 2'd1;
          end
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsp_assembler.sv
module bsp_assembler
  import bsp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     capture,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES-1:0][1:0]    lane_idx,
  input  logic [LANES*BYTE_W-1:0]  din,
  output logic [4*BYTE_W-1:0]      rdata
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rdata <= '0;
    end else if (capture) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l])
          rdata[{lane_idx[l], 3'b000} +: BYTE_W] <= din[l*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/bsp_bus_splitter.sv
module bsp_bus_splitter
  import bsp_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_data,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              bus_strobe_n,
  output logic              hi_lane_n,
  output logic              lo_lane_n,
  output logic              bus_write,
  output logic              bus_data_cyc,
  output logic              bus_mem,
  output logic              bus_locked_n,
  output logic              bus_grant,
  output logic [15:0]       bus_dout,
  output logic              bus_dout_en,
  input  logic [15:0]       bus_din,
  input  logic              bus_rdy_n
);

  // latched request
  logic [ADDR_W-1:0] q_addr;
  logic [2:0]        q_nbytes;
  logic              q_write, q_mem, q_data;
  logic [31:0]       q_wdata;

  // internal events, named for the checker
  bus_state_e        state;
  logic [1:0]        cyc_idx;
  logic [1:0]        ncyc;
  logic              start;
  logic              cycle_end;
  logic              last_end;
  logic              bus_active;
  logic              bus_t2;
  logic              force_idle;

  logic [ADDR_W-2:0]        word_addr;
  logic [LANES-1:0]         lane_en;
  logic [LANES-1:0][1:0]    lane_idx;
  logic [LANES*BYTE_W-1:0]  lane_wdata;

  assign req_ready  = !rst && (state == BUS_IDLE);
  assign start      = req_valid && req_ready;
  assign ncyc       = cycles_for(q_addr[0], q_nbytes);
  assign bus_active = (state != BUS_IDLE);
  assign bus_t2     = (state == BUS_T2);
  assign force_idle = rst || !bus_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr   <= '0;
      q_nbytes <= 3'd1;
      q_write  <= 1'b0;
      q_mem    <= 1'b0;
      q_data   <= 1'b1;
      q_wdata  <= '0;
    end else if (start) begin
      q_addr   <= req_addr;
      q_nbytes <= size_to_bytes(req_size);
      q_write  <= req_write;
      q_mem    <= req_mem;
      q_data   <= req_data;
      q_wdata  <= req_wdata;
    end
  end

  bsp_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rdy_n     (bus_rdy_n),
    .ncyc      (ncyc),
    .state     (state),
    .cyc_idx   (cyc_idx),
    .cycle_end (cycle_end),
    .last_end  (last_end)
  );

  bsp_planner #(.ADDR_W(ADDR_W)) u_plan (
    .base_addr  (q_addr),
    .nbytes     (q_nbytes),
    .cyc_idx    (cyc_idx),
    .wdata      (q_wdata),
    .word_addr  (word_addr),
    .lane_en    (lane_en),
    .lane_idx   (lane_idx),
    .lane_wdata (lane_wdata)
  );

  bsp_assembler u_asm (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .capture  (cycle_end && !q_write),
    .lane_en  (lane_en),
    .lane_idx (lane_idx),
    .din      (bus_din),
    .rdata    (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= last_end;
  end

  // bus pins: idle pattern whenever nothing is in flight
  assign bus_addr     = force_idle ? '1   : word_addr;
  assign bus_strobe_n = rst || (state != BUS_T1);
  assign hi_lane_n    = force_idle ? 1'b0 : !lane_en[1];
  assign lo_lane_n    = force_idle ? 1'b0 : !lane_en[0];
  assign bus_write    = force_idle ? 1'b0 : q_write;
  assign bus_data_cyc = force_idle ? 1'b1 : q_data;
  assign bus_mem      = force_idle ? 1'b0 : q_mem;
  assign bus_locked_n = 1'b1;
  assign bus_grant    = 1'b0;
  assign bus_dout     = lane_wdata;
  assign bus_dout_en  = !force_idle && q_write;

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_strobe_n,
  input logic          hi_lane_n,
  input logic          lo_lane_n,
  input logic [AW-2:0] bus_addr,
  input logic          bus_write,
  input logic          bus_data_cyc,
  input logic          bus_mem,
  input logic          bus_locked_n,
  input logic          bus_grant,
  input logic          bus_dout_en,
  input logic          bus_rdy_n,
  input logic          done,
  input logic          req_ready,
  input logic          bus_active,
  input logic          bus_t2,
  input logic          cycle_end
);

  always @(posedge clk) begin
    if (rst) begin
      assert_reset_pins_R1: assert (bus_strobe_n && !hi_lane_n && !lo_lane_n &&
                                    (&bus_addr) && !bus_write && bus_data_cyc &&
                                    !bus_mem && bus_locked_n && !bus_grant &&
                                    !bus_dout_en);
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe_n |=> bus_strobe_n);

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_t2 && bus_rdy_n) |=> (bus_t2 && $stable(bus_addr) &&
                               $stable(hi_lane_n) && $stable(lo_lane_n)));

  assert_strobe_after_end_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe_n |-> !cycle_end);

  assert_lane_used_R2: assert property (@(posedge clk) disable iff (rst)
    bus_active |-> !(hi_lane_n && lo_lane_n));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    bus_active |-> !req_ready);

  assert_drive_only_write_R8: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> (bus_active && bus_write));

endmodule

bind bsp_bus_splitter bsp_checker #(.AW(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_strobe_n (bus_strobe_n),
  .hi_lane_n    (hi_lane_n),
  .lo_lane_n    (lo_lane_n),
  .bus_addr     (bus_addr),
  .bus_write    (bus_write),
  .bus_data_cyc (bus_data_cyc),
  .bus_mem      (bus_mem),
  .bus_locked_n (bus_locked_n),
  .bus_grant    (bus_grant),
  .bus_dout_en  (bus_dout_en),
  .bus_rdy_n    (bus_rdy_n),
  .done         (done),
  .req_ready    (req_ready),
  .bus_active   (bus_active),
  .bus_t2       (bus_t2),
  .cycle_end    (cycle_end)
);

// File: tb/bsp_bus_splitter_tb.sv
module bsp_bus_splitter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_mem = 1'b1;
  logic        req_data = 1'b1;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [22:0] bus_addr;
  logic        bus_strobe_n, hi_lane_n, lo_lane_n;
  logic        bus_write, bus_data_cyc, bus_mem, bus_locked_n, bus_grant;
  logic [15:0] bus_dout;
  logic        bus_dout_en;
  logic [15:0] bus_din;
  logic        bus_rdy_n = 1'b1;

  always #2 clk = ~clk;   // 250 MHz

  bsp_bus_splitter u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_mem(req_mem), .req_data(req_data), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_strobe_n(bus_strobe_n), .hi_lane_n(hi_lane_n), .lo_lane_n(lo_lane_n),
    .bus_write(bus_write), .bus_data_cyc(bus_data_cyc), .bus_mem(bus_mem),
    .bus_locked_n(bus_locked_n), .bus_grant(bus_grant), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n)
  );

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic [22:0] waddr;
    logic        hi_n;
    logic        lo_n;
    logic [15:0] wd;
    int          waits;
  } cyc_t;

  cyc_t  expq[$];
  logic  exp_wr, exp_mem, exp_dc;
  string cur_tag = "R2";

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  // slave model returns a known pattern on both lanes
  assign bus_din = {mem_byte({bus_addr, 1'b1}), mem_byte({bus_addr, 1'b0})};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor and ready responder
  int wait_left = 0;
  bit in_cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_strobe_n) begin
        if (expq.size() == 0) begin
          check(0, "R10", "unexpected bus cycle", {9'b0, bus_addr}, 0);
        end else begin
          cyc_t c;
          c = expq.pop_front();
          check(bus_addr == c.waddr, cur_tag, "word address", {9'b0, bus_addr}, {9'b0, c.waddr});
          check({hi_lane_n, lo_lane_n} == {c.hi_n, c.lo_n}, cur_tag, "lane enables",
                {30'b0, hi_lane_n, lo_lane_n}, {30'b0, c.hi_n, c.lo_n});
          check({bus_write, bus_mem, bus_data_cyc} == {exp_wr, exp_mem, exp_dc}, "R11",
                "cycle type", {29'b0, bus_write, bus_mem, bus_data_cyc},
                {29'b0, exp_wr, exp_mem, exp_dc});
          check(bus_dout_en == exp_wr, "R8", "data drive enable", {31'b0, bus_dout_en}, {31'b0, exp_wr});
          if (exp_wr)
            check(bus_dout == c.wd, "R8", "write lanes", {16'b0, bus_dout}, {16'b0, c.wd});
          wait_left = c.waits;
          in_cyc    = 1;
        end
        bus_rdy_n = 1'b0;   // must be ignored in the first state (R7)
      end else if (in_cyc) begin
        if (wait_left > 0) begin
          bus_rdy_n = 1'b1;
          wait_left--;
        end else begin
          bus_rdy_n = 1'b0;
          in_cyc    = 0;
        end
      end else begin
        bus_rdy_n = 1'b1;
      end
    end
  end

  task automatic idle_check(input string tag);
    check(bus_strobe_n && !hi_lane_n && !lo_lane_n && (&bus_addr) && !bus_write &&
          bus_data_cyc && !bus_mem && bus_locked_n && !bus_grant && !bus_dout_en,
          tag, "idle pattern",
          {bus_addr, bus_strobe_n, hi_lane_n, lo_lane_n, bus_write, bus_data_cyc,
           bus_mem, bus_locked_n, bus_grant, bus_dout_en},
          {23'h7FFFFF, 9'b1_00_0_1_0_1_0_0});
  endtask

  task automatic run(input logic [23:0] addr, input logic [1:0] size, input logic wr,
                     input logic mem, input logic dc, input logic [31:0] wd,
                     input int wmode, input bit hold_busy, input string tag);
    cyc_t items[4];
    int n = 0;
    int nb;
    int total = 0;
    int cnt;
    logic [31:0] exp_rd = '0;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    for (int i = 0; i < nb; i++) begin
      logic [23:0] b;
      b = addr + 24'(i);
      if (n == 0 || items[n-1].waddr != b[23:1]) begin
        items[n].waddr = b[23:1];
        items[n].hi_n  = 1'b1;
        items[n].lo_n  = 1'b1;
        items[n].wd    = '0;
        items[n].waits = (wmode == 0) ? 0 : (wmode + n) % 3;
        n++;
      end
      if (b[0]) begin
        items[n-1].hi_n = 1'b0;
        items[n-1].wd[15:8] = wd[8*i +: 8];
      end else begin
        items[n-1].lo_n = 1'b0;
        items[n-1].wd[7:0] = wd[8*i +: 8];
      end
      exp_rd[8*i +: 8] = mem_byte(b);
    end
    for (int k = 0; k < n; k++) begin
      total += 2 + items[k].waits;
      expq.push_back(items[k]);
    end
    exp_wr = wr; exp_mem = mem; exp_dc = dc; cur_tag = tag;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready when idle", {31'b0, req_ready}, 1);
    req_addr = addr; req_size = size; req_write = wr; req_mem = mem;
    req_data = dc; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    cnt = 1;
    if (hold_busy) begin
      // fields change while busy; must not be sampled (R10)
      req_addr = ~addr; req_size = 2'd0; req_write = ~wr; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (hold_busy && cnt == 4) req_valid = 1'b0;
    end
    check(cnt == total + 1, "R7", "done cycle count", cnt, total + 1);
    check(expq.size() == 0, tag, "cycles left unissued", expq.size(), 0);
    if (!wr) check(rdata == exp_rd, "R9", "assembled read data", rdata, exp_rd);
    @(negedge clk);
    check(!done, "R10", "done single pulse", {31'b0, done}, 0);
    idle_check("R1");
    expq.delete();
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1");
    check(!req_ready && !done, "R1", "ready/done in reset", {30'b0, req_ready, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R1");
    run(24'h001234, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0,          0, 0, "R2");
    run(24'h001235, 2'd0, 1'b1, 1'b1, 1'b1, 32'h000000A7,   1, 0, "R2");
    run(24'h00A010, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0000BEEF,   0, 0, "R3");
    run(24'h00A012, 2'd1, 1'b0, 1'b1, 0,    32'h0,          2, 0, "R3");
    run(24'h034567, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0,          0, 0, "R4");
    run(24'h034569, 2'd1, 1'b1, 1'b1, 1'b1, 32'h00005AC3,   1, 0, "R4");
    run(24'h100200, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0,          0, 0, "R5");
    run(24'h100204, 2'd3, 1'b1, 1'b1, 1'b1, 32'h11223344,   2, 0, "R5");
    run(24'h2ABCD1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0,          1, 0, "R6");
    run(24'h2ABCD3, 2'd2, 1'b1, 1'b1, 1'b1, 32'hA1B2C3D4,   0, 0, "R6");
    run(24'h8000FB, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0,          0, 0, "R11");
    run(24'hFFFFFF, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0,          2, 0, "R11");
    run(24'h0000F3, 2'd2, 1'b1, 1'b1, 1'b1, 32'hCAFEF00D,   2, 1, "R10");
    repeat (2) @(negedge clk);
    idle_check("R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule